// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner folds a wide vector of level-sensitive interrupt sources into one request line per group of eight. Every source has its own enable bit. Software reads each source's level unfiltered (raw status) and filtered by its enable (masked status). A single summary word tells the interrupt handler which groups have a pending source, so it needs only one read to learn where to look. Each group output is a registered OR of that group's masked sources, and it drives one input of a downstream interrupt controller.

Four groups share one 32-bit register word, so a bank of four groups takes a 16-byte window: enable-set, enable-clear, raw status and masked status. Enables change only through writes of ones, to the set or the clear register. This lets two agents change different sources without a read-modify-write race. Some bit positions have no source wired to them. A per-source parameter marks these positions, and they stay silent in all registers and outputs.

Top module: `irq_combiner`

## Requirements
- R1: After reset all enables are 0, every `irq_o` bit is 0 and `rsp_valid_o` is 0.
- R2: A write to a bank's enable-set register (offset 0x10*bank + 0x0) enables each source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to a bank's enable-clear register (offset 0x10*bank + 0x4) disables each source whose data bit is 1. Bits written as 0 leave their enables unchanged.
- R4: A read of either the enable-set or the enable-clear offset returns the bank's current enable mask.
- R5: Raw status (offset 0x10*bank + 0x8) returns the level of each source, whether or not it is enabled, two clock edges after the input changes (two-flop synchronizer).
- R6: Masked status (offset 0x10*bank + 0xC) returns raw status ANDed with the enable bits.
- R7: Source b of group g appears at bit (g mod 4)*8 + b of bank g/4. Bank k occupies byte offsets 0x10*k to 0x10*k + 0xC.
- R8: The pending-summary register at offset 0x100 has bit g set exactly when any masked source of group g is active. Bits above the group count read 0.
- R9: `irq_o[g]` is the registered OR of group g's masked status. It changes one clock edge after raw status does.
- R10: A position cleared in parameter `SRC_USED` reads 0 in enable, raw and masked status, and never contributes to pending or `irq_o`, even when written. By default group 14 has no sources and group 13 has only source 1, so the used mask of bank 3 is 0xFF0002FF.
- R11: Unaligned addresses (address bits [1:0] not 0), bank offsets at or beyond 0x80, and every other offset except 0x100 read as 0. Writes to them change no enable.
- R12: `req_ready_o` is always 1. Each request with `req_valid_i` high produces `rsp_valid_o` high on the next cycle, with the read data in `rsp_rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_GROUPS*GRP_W (256) | Level interrupt sources, group-major |
| req_valid_i | input | 1 | Register access request |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (12) | Byte address |
| req_wdata_i | input | WORD_W (32) | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | WORD_W (32) | Read data (0 for writes and unmapped reads) |
| irq_o | output | N_GROUPS (32) | Per-group combined interrupt |

## Verification
The bench drives source patterns into several banks and checks that each bit lands at its group-and-source position in raw status, masked status and the pending summary. If the bank or shift were decoded wrongly, the bits would show up in a neighbouring group. It checks that zero bits in set and clear writes are inert; a design that wrote the enable register directly would drop earlier enables. It drives all ones into a bank that has unused positions, where a design that ignored the used mask would raise group 14. It also measures the exact synchronizer and output latency, and it probes unaligned and out-of-range addresses, where a design that decoded too few address bits would alias into bank 0 or the summary register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // register selector inside a 16-byte bank window, decoded from addr[3:2]
  typedef enum logic [1:0] {
    SEL_EN_SET = 2'd0,
    SEL_EN_CLR = 2'd1,
    SEL_RAW    = 2'd2,
    SEL_MASKED = 2'd3
  } reg_sel_e;

  localparam int unsigned BANK_SPAN_B = 16;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
  parameter int unsigned        WORD_W = 32,
  parameter logic [WORD_W-1:0]  USED   = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] en_o
);
  logic [WORD_W-1:0] en_q, set_m, clr_m;

  assign set_m = set_i ? wdata_i : '0;
  assign clr_m = clr_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_m) & ~clr_m & USED;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irqc_group_or.sv
module irqc_group_or #(
  parameter int unsigned N_GROUPS = 32,
  parameter int unsigned GRP_W    = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GROUPS*GRP_W-1:0] masked_i,
  output logic [N_GROUPS-1:0]       any_o,
  output logic [N_GROUPS-1:0]       irq_o
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign any_o[g] = |masked_i[g*GRP_W +: GRP_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[g] <= 1'b0;
      else         irq_o[g] <= any_o[g];
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int unsigned N_GROUPS  = 32,
  parameter int unsigned GRP_W     = 8,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 12'h100,
  parameter logic [N_GROUPS*GRP_W-1:0] SRC_USED =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FF0002FF_FFFFFFFF_FFFFFFFF_FFFFFFFF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_GROUPS*GRP_W-1:0] src_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_write_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [WORD_W-1:0]         req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [WORD_W-1:0]         rsp_rdata_o,
  output logic [N_GROUPS-1:0]       irq_o
);
  localparam int unsigned N_SRC      = N_GROUPS * GRP_W;
  localparam int unsigned GRPS_PER_W = WORD_W / GRP_W;
  localparam int unsigned N_BANKS    = N_GROUPS / GRPS_PER_W;
  localparam int unsigned BANK_IDX_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int unsigned SPAN_LSB   = $clog2(BANK_SPAN_B);
  localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(N_BANKS * BANK_SPAN_B);

  logic [N_SRC-1:0]    raw_sync, raw_used, en_all, masked;
  logic [N_GROUPS-1:0] grp_any;

  // source synchronization
  irqc_sync #(.W(N_SRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (raw_sync)
  );

  assign raw_used = raw_sync & SRC_USED;
  assign masked   = raw_used & en_all;

  // address decode
  logic       acc_wr, aligned, in_banks, is_pend;
  logic [BANK_IDX_W-1:0] bank_idx;
  reg_sel_e   sel;

  assign req_ready_o = 1'b1;
  assign acc_wr   = req_valid_i & req_write_i;
  assign aligned  = (req_addr_i[1:0] == 2'b00);
  assign in_banks = aligned && (req_addr_i < BANK_END);
  assign is_pend  = aligned && (req_addr_i == PEND_ADDR);
  assign bank_idx = req_addr_i[SPAN_LSB +: BANK_IDX_W];
  assign sel      = reg_sel_e'(req_addr_i[3:2]);

  logic [WORD_W-1:0] en_w  [N_BANKS];
  logic [WORD_W-1:0] raw_w [N_BANKS];
  logic [WORD_W-1:0] msk_w [N_BANKS];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic hit, set_we, clr_we;
    assign hit    = acc_wr && in_banks && (bank_idx == BANK_IDX_W'(b));
    assign set_we = hit && (sel == SEL_EN_SET);
    assign clr_we = hit && (sel == SEL_EN_CLR);

    irqc_en_bank #(
      .WORD_W(WORD_W),
      .USED  (SRC_USED[b*WORD_W +: WORD_W])
    ) u_en (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_we),
      .clr_i  (clr_we),
      .wdata_i(req_wdata_i),
      .en_o   (en_w[b])
    );

    assign en_all[b*WORD_W +: WORD_W] = en_w[b];
    assign raw_w[b] = raw_used[b*WORD_W +: WORD_W];
    assign msk_w[b] = masked[b*WORD_W +: WORD_W];
  end

  // group combining
  irqc_group_or #(.N_GROUPS(N_GROUPS), .GRP_W(GRP_W)) u_or (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .masked_i(masked),
    .any_o   (grp_any),
    .irq_o   (irq_o)
  );

  // read path
  logic [WORD_W-1:0] pend_word, rdata_d;
  assign pend_word = WORD_W'(grp_any);

  always_comb begin
    rdata_d = '0;
    if (req_valid_i && !req_write_i) begin
      if (is_pend) begin
        rdata_d = pend_word;
      end else if (in_banks) begin
        unique case (sel)
          SEL_EN_SET, SEL_EN_CLR: rdata_d = en_w[bank_idx];
          SEL_RAW:                rdata_d = raw_w[bank_idx];
          SEL_MASKED:             rdata_d = msk_w[bank_idx];
          default:                rdata_d = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int unsigned N_GROUPS = 32,
  parameter int unsigned GRP_W    = 8,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [N_GROUPS*GRP_W-1:0] SRC_USED = '1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_valid_i,
  input logic                      req_write_i,
  input logic [ADDR_W-1:0]         req_addr_i,
  input logic [WORD_W-1:0]         req_wdata_i,
  input logic                      rsp_valid_o,
  input logic [WORD_W-1:0]         rsp_rdata_o,
  input logic [N_GROUPS-1:0]       irq_o,
  input logic [N_GROUPS*GRP_W-1:0] en_i,
  input logic [N_GROUPS-1:0]       grp_any_i
);
  localparam logic [WORD_W-1:0] USED0 = SRC_USED[WORD_W-1:0];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (irq_o == '0 && !rsp_valid_o && en_i == '0);
    end
  end

  p_set_bank0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == '0) |=>
      ((en_i[WORD_W-1:0] & $past(req_wdata_i & USED0)) == $past(req_wdata_i & USED0)));

  p_clr_bank0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(4)) |=>
      ((en_i[WORD_W-1:0] & $past(req_wdata_i)) == '0));

  p_irq_track_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(grp_any_i)));

  p_en_used_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i & ~SRC_USED) == '0);

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_empty
    if (SRC_USED[g*GRP_W +: GRP_W] == '0) begin : g_chk
      p_empty_group_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o[g]);
    end
  end

  p_en_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || !req_write_i) |=> $stable(en_i));

  p_unaligned_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_addr_i[1:0] != 2'b00) |=> (rsp_rdata_o == '0));

  p_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_no_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
endmodule

bind irq_combiner irqc_chk #(
  .N_GROUPS(N_GROUPS),
  .GRP_W   (GRP_W),
  .WORD_W  (WORD_W),
  .ADDR_W  (ADDR_W),
  .SRC_USED(SRC_USED)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .irq_o      (irq_o),
  .en_i       (en_all),
  .grp_any_i  (grp_any)
);

// File: tb/irq_combiner_bench.sv
`timescale 1ns/1ps
module irq_combiner_bench;
  localparam logic [255:0] USED =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FF0002FF_FFFFFFFF_FFFFFFFF_FFFFFFFF;

  // {bank[2:0], enable_set_word[31:0], source_word[31:0]}
  localparam int NV = 7;
  localparam logic [66:0] VEC [NV] = '{
    {3'd0, 32'h0000_00FF, 32'h0000_0081},
    {3'd1, 32'hFFFF_0000, 32'h0F0F_0F0F},
    {3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {3'd5, 32'h0008_0000, 32'h0008_0000},
    {3'd7, 32'h8000_0000, 32'h7FFF_FFFF},
    {3'd2, 32'h00FF_FF00, 32'h00FF_FF00},
    {3'd3, 32'h0000_FF00, 32'h0000_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [255:0] src = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  irq_combiner u_irq_combiner (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata),
    .irq_o      (irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    logic v;
    bus_rd(a, d, v);
    check(v && d == exp, req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic v;

    idle(3);
    // R1: reset state
    check(irq == '0, "R1 irq_o in reset", irq, 32'h0);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    check(req_ready == 1'b1, "R12 ready", {31'h0, req_ready}, 32'h1);
    rd_chk(12'h000, 32'h0, "R1 enables after reset");
    rd_chk(12'h074, 32'h0, "R1 enables bank7 after reset");

    // R2: zero bits of set write are inert
    bus_wr(12'h000, 32'h0000_000F);
    bus_wr(12'h000, 32'h0000_00F0);
    rd_chk(12'h000, 32'h0000_00FF, "R2 set accumulates");
    // R3: clear
    bus_wr(12'h004, 32'h0000_000F);
    rd_chk(12'h000, 32'h0000_00F0, "R3 clear selected bits");
    bus_wr(12'h004, 32'h0000_0000);
    // R4: readback at clear offset
    rd_chk(12'h004, 32'h0000_00F0, "R4 read via clear offset");

    // R11: unmapped / unaligned writes change nothing
    bus_wr(12'h001, 32'hFFFF_FFFF);
    bus_wr(12'h006, 32'hFFFF_FFFF);
    bus_wr(12'h080, 32'hFFFF_FFFF);
    bus_wr(12'h104, 32'hFFFF_FFFF);
    rd_chk(12'h000, 32'h0000_00F0, "R11 unmapped writes ignored");
    rd_chk(12'h002, 32'h0, "R11 unaligned read");
    rd_chk(12'h080, 32'h0, "R11 past last bank read");
    rd_chk(12'h104, 32'h0, "R11 offset 0x104 read");
    bus_wr(12'h004, 32'hFFFF_FFFF);

    // R5/R6: raw shows disabled source, masked does not
    @(negedge clk); src[40] = 1'b1;           // group 5 source 0 -> bank1 bit 8
    idle(3);
    rd_chk(12'h018, 32'h0000_0100, "R5 raw ignores enable");
    rd_chk(12'h01C, 32'h0, "R6 masked with enable off");
    check(irq == '0, "R9 no irq while disabled", irq, 32'h0);
    @(negedge clk); src[40] = 1'b0;
    idle(3);

    // R9: latency from input through synchronizer to irq_o
    bus_wr(12'h000, 32'h0000_0001);
    @(negedge clk); src[0] = 1'b1;
    idle(2);
    rd_chk(12'h008, 32'h0000_0001, "R5 raw after two edges");
    src[0] = 1'b0;
    idle(4);
    @(negedge clk); src[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(irq[0] == 1'b0, "R9 irq not before third edge", {31'h0, irq[0]}, 32'h0);
    @(negedge clk);
    check(irq[0] == 1'b1, "R9 irq on third edge", {31'h0, irq[0]}, 32'h1);
    @(negedge clk); src[0] = 1'b0;
    idle(3);
    check(irq[0] == 1'b0, "R9 irq drops", {31'h0, irq[0]}, 32'h0);
    bus_wr(12'h004, 32'hFFFF_FFFF);

    // R7 R8 R10: table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  bk;
      logic [31:0] en_w, src_w, used_w, raw_e, msk_e, pend_e;
      logic [11:0] base;
      bk    = VEC[i][66:64];
      en_w  = VEC[i][63:32];
      src_w = VEC[i][31:0];
      base  = {5'd0, bk, 4'h0};
      used_w = USED[bk*32 +: 32];
      raw_e  = src_w & used_w;
      msk_e  = raw_e & en_w;
      pend_e = '0;
      for (int k = 0; k < 4; k++) pend_e[bk*4 + k] = |msk_e[k*8 +: 8];

      @(negedge clk); src = '0;
      bus_wr(base + 12'h4, 32'hFFFF_FFFF);
      @(negedge clk); src[bk*32 +: 32] = src_w;
      bus_wr(base, en_w);
      idle(4);
      rd_chk(base, en_w & used_w, "R10 enable readback masked by used");
      rd_chk(base + 12'h8, raw_e, "R7 raw bit position");
      rd_chk(base + 12'hC, msk_e, "R6 masked status");
      rd_chk(12'h100, pend_e, "R8 pending summary");
      check(irq == pend_e, "R10 irq_o per group", irq, pend_e);
    end

    // R12: response after read, none when idle
    @(negedge clk); src = '0;
    bus_rd(12'h100, d, v);
    check(v == 1'b1, "R12 rsp_valid after request", {31'h0, v}, 32'h1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R12 no rsp when idle", {31'h0, rsp_valid}, 32'h0);

    finish_run();
  end
endmodule